// File: doc/BRIEF.md
# Phase-gated pipelined fixed-point multiplier

This block multiplies two fixed-point operands and delivers the full-precision product, with no rounding and no saturation. Each operand has a configurable number of integer bits and fraction bits. The operands are read either as two's complement values or as unsigned values. The product keeps every bit: its integer part is the sum of the two operands' integer widths, and its fraction part is the sum of their fraction widths.

The product goes through a chain of register stages, and the number of stages is a parameter. When that number is zero, the block is a plain combinational multiplier. When it is one or more, a clock enable and an asynchronous clear come into play. A repeating phase pattern then decides on which cycles the chain captures new data, so the same block can also drop samples at a fixed rate. The pattern is a bit string whose most significant bit stands for phase 1. The phase counter steps on every enabled cycle. The chain captures only when the enable is high and the pattern bit for the current phase is 1.

Top module: `fxp_phase_mult`

## Requirements
- R1: With SIGNED=1, p_out is the two's complement product of a_in and b_in. It is (A_INT+B_INT+A_FRAC+B_FRAC) bits wide, and the binary point sits A_FRAC+B_FRAC bits from the LSB. The product is exact for every operand pair, including most-negative times most-negative.
- R2: With SIGNED=0, both operands are zero-extended, and p_out is their exact unsigned product.
- R3: With STAGES=0, p_out follows the operands combinationally, within the same cycle. In that case en and arst_n have no effect on it.
- R4: With STAGES>=1, PHASE_PAT=1'b1 and en held high, p_out equals the product of the operands applied STAGES clock edges earlier.
- R5: Bit PHASE_LEN-1 of PHASE_PAT is phase 1, and the next lower bit is the following phase. All register stages capture at a clock edge only when en is high and the current phase's bit is 1. Pattern 2'b10 passes every second sample, and pattern 4'b0100 passes only the sample on phase 2 of each group of four.
- R6: While en is low, every register stage and the phase counter hold their values, whatever the operands do.
- R7: When arst_n goes low, all register stages clear to zero at once, without waiting for a clock edge, and the phase returns to phase 1. Release of arst_n is synchronized over two clock edges.
- R8: The phase counter advances on every edge with en high, whether or not that phase captures. It wraps from phase PHASE_LEN back to phase 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the register stages and the phase counter |
| arst_n | input | 1 | Active-low asynchronous clear (unused when STAGES=0) |
| en | input | 1 | Clock enable for the stages and the phase counter (unused when STAGES=0) |
| a_in | input | A_INT+A_FRAC | Operand A |
| b_in | input | B_INT+B_FRAC | Operand B |
| p_out | output | A_INT+A_FRAC+B_INT+B_FRAC | Full-precision product |

## Verification
The same stream of operand pairs drives five instances at once: a combinational one, a signed one with two stages, an unsigned one, and two phase-gated ones using patterns 2'b10 and 4'b0100. A difference between the signed and unsigned results shows whether sign extension is right. The operands include most-negative squared, most-negative times most-positive and all-ones. Comparing the pattern instances against the ungated one shows which samples are dropped and whether the phase count is right. It also shows whether the counter keeps stepping on cycles that do not capture. Enable-low stretches with changing operands, and a clear asserted between clock edges, show hold behaviour, immediate clearing and the restart at phase 1.

// File: rtl/fxp_pkg.sv
package fxp_pkg;
  // Width of a counter that has to reach n-1; never less than one bit.
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fxp_rst_sync.sv
module fxp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_sync = s2_q;
endmodule

// File: rtl/fxp_phase_gen.sv
module fxp_phase_gen #(
  parameter int              LEN = 1,
  parameter logic [LEN-1:0]  PAT = '1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic cap
);
  import fxp_pkg::*;
  localparam int CW = cnt_width(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sel;

  // Next-state: step on every enabled cycle, wrap after the last phase.
  always_comb begin
    cnt_d = cnt_q;
    if (en) begin
      if (cnt_q == LAST) cnt_d = '0;
      else               cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Pattern MSB is phase 1.
  always_comb begin
    sel = 1'b0;
    for (int i = 0; i < LEN; i++) begin
      if (cnt_q == CW'(i)) sel = PAT[LEN-1-i];
    end
  end

  assign cap = en & sel;

  a_r8_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt_q == LAST) |=> (cnt_q == '0));
  a_r6_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q));
endmodule

// File: rtl/fxp_pipe.sv
module fxp_pipe #(
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [DEPTH];
  logic [W-1:0] stg_d [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) stg_d[i] = stg_q[i];
    if (cap) begin
      stg_d[0] = d;
      for (int i = 1; i < DEPTH; i++) stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign q = stg_q[DEPTH-1];

  a_r5_first_load: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (stg_q[0] == $past(d)));
  a_r6_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(q));
endmodule

// File: rtl/fxp_phase_mult.sv
module fxp_phase_mult #(
  parameter int                    A_INT     = 4,
  parameter int                    A_FRAC    = 4,
  parameter int                    B_INT     = 4,
  parameter int                    B_FRAC    = 4,
  parameter bit                    SIGNED    = 1'b1,
  parameter int                    STAGES    = 2,
  parameter int                    PHASE_LEN = 1,
  parameter logic [PHASE_LEN-1:0]  PHASE_PAT = '1
) (
  input  logic                                       clk,
  input  logic                                       arst_n,
  input  logic                                       en,
  input  logic [A_INT+A_FRAC-1:0]                    a_in,
  input  logic [B_INT+B_FRAC-1:0]                    b_in,
  output logic [A_INT+A_FRAC+B_INT+B_FRAC-1:0]       p_out
);
  localparam int A_W = A_INT + A_FRAC;
  localparam int B_W = B_INT + B_FRAC;
  localparam int P_W = A_W + B_W;

  logic [P_W-1:0] ax, bx, prod;

  // Operand extension to product width selects the number format.
  generate
    if (SIGNED) begin : g_sext
      assign ax = {{B_W{a_in[A_W-1]}}, a_in};
      assign bx = {{A_W{b_in[B_W-1]}}, b_in};
    end else begin : g_zext
      assign ax = {{B_W{1'b0}}, a_in};
      assign bx = {{A_W{1'b0}}, b_in};
    end
  endgenerate

  assign prod = ax * bx;

  generate
    if (STAGES == 0) begin : g_comb
      assign p_out = prod;
    end else begin : g_reg
      logic rst_n_sync;
      logic cap;

      fxp_rst_sync u_rst (
        .clk        (clk),
        .arst_n     (arst_n),
        .rst_n_sync (rst_n_sync)
      );

      fxp_phase_gen #(
        .LEN (PHASE_LEN),
        .PAT (PHASE_PAT)
      ) u_phase (
        .clk   (clk),
        .rst_n (rst_n_sync),
        .en    (en),
        .cap   (cap)
      );

      fxp_pipe #(
        .W     (P_W),
        .DEPTH (STAGES)
      ) u_pipe (
        .clk   (clk),
        .rst_n (rst_n_sync),
        .cap   (cap),
        .d     (prod),
        .q     (p_out)
      );

      a_r7_clear_zero: assert property (@(posedge clk)
        !arst_n |-> (p_out == '0));
    end
  endgenerate
endmodule

// File: tb/tb_fxp_phase_mult.sv
`timescale 1ns/1ps
module tb_fxp_phase_mult;
  logic        clk = 1'b0;
  logic        arst_n;
  logic        en;
  logic [7:0]  a_in, b_in;
  logic [15:0] p_s, p_u, p_h, p_q, p_c;

  int errors = 0;
  int checks = 0;

  localparam logic [1:0] PAT_H = 2'b10;
  localparam logic [3:0] PAT_Q = 4'b0100;
  localparam int NV = 12;
  localparam logic [15:0] VEC [NV] = '{
    16'h8080, 16'h807F, 16'h7F7F, 16'hFFFF, 16'h01FF, 16'h0080,
    16'h1010, 16'hF010, 16'h5AC3, 16'h7F80, 16'h2345, 16'h8181
  };

  always #4 clk = ~clk;

  fxp_phase_mult #(.STAGES(2)) dut (
    .clk(clk), .arst_n(arst_n), .en(en), .a_in(a_in), .b_in(b_in), .p_out(p_s));
  fxp_phase_mult #(.A_INT(8), .A_FRAC(0), .B_INT(8), .B_FRAC(0), .SIGNED(1'b0), .STAGES(1)) dut_u (
    .clk(clk), .arst_n(arst_n), .en(en), .a_in(a_in), .b_in(b_in), .p_out(p_u));
  fxp_phase_mult #(.STAGES(2), .PHASE_LEN(2), .PHASE_PAT(PAT_H)) dut_h (
    .clk(clk), .arst_n(arst_n), .en(en), .a_in(a_in), .b_in(b_in), .p_out(p_h));
  fxp_phase_mult #(.STAGES(2), .PHASE_LEN(4), .PHASE_PAT(PAT_Q)) dut_q (
    .clk(clk), .arst_n(arst_n), .en(en), .a_in(a_in), .b_in(b_in), .p_out(p_q));
  fxp_phase_mult #(.STAGES(0)) dut_c (
    .clk(clk), .arst_n(arst_n), .en(en), .a_in(a_in), .b_in(b_in), .p_out(p_c));

  // Reference models
  logic [15:0] m_s [2];
  logic [15:0] m_h [2];
  logic [15:0] m_q [2];
  logic [15:0] m_u;
  int ph_h, ph_q;

  function automatic logic [15:0] sprod(input logic [7:0] a, input logic [7:0] b);
    logic signed [15:0] x, y;
    x = {{8{a[7]}}, a};
    y = {{8{b[7]}}, b};
    return x * y;
  endfunction

  function automatic logic [15:0] uprod(input logic [7:0] a, input logic [7:0] b);
    return {8'h00, a} * {8'h00, b};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_s[0] = '0; m_s[1] = '0; m_h[0] = '0; m_h[1] = '0;
    m_q[0] = '0; m_q[1] = '0; m_u = '0;
    ph_h = 0; ph_q = 0;
  endtask

  // Called at a falling edge: drive operands, predict the next rising edge.
  task automatic step(input logic [7:0] a, input logic [7:0] b, input logic e);
    a_in = a; b_in = b; en = e;
    if (e) begin
      m_s[1] = m_s[0]; m_s[0] = sprod(a, b);
      m_u = uprod(a, b);
      if (PAT_H[1-ph_h]) begin m_h[1] = m_h[0]; m_h[0] = sprod(a, b); end
      if (PAT_Q[3-ph_q]) begin m_q[1] = m_q[0]; m_q[0] = sprod(a, b); end
      ph_h = (ph_h + 1) % 2;
      ph_q = (ph_q + 1) % 4;
    end
    #1;
    chk("R1 R3 combinational product", p_c, sprod(a, b));
    @(negedge clk);
    chk("R1 R4 signed two-stage latency", p_s, m_s[1]);
    chk("R2 unsigned product", p_u, m_u);
    chk("R5 pattern 10", p_h, m_h[1]);
    chk("R5 R8 pattern 0100", p_q, m_q[1]);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] hs, hh, hq, hu;
    arst_n = 1'b0; en = 1'b0; a_in = 8'h00; b_in = 8'h00;
    model_clear();
    repeat (3) @(negedge clk);
    // R7: reset state
    chk("R7 reset state signed", p_s, 16'h0000);
    chk("R7 reset state unsigned", p_u, 16'h0000);
    chk("R7 reset state pattern", p_q, 16'h0000);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Table walk with enable high
    for (int i = 0; i < NV; i++) step(VEC[i][15:8], VEC[i][7:0], 1'b1);

    // R6: enable low, operands change, nothing moves
    hs = p_s; hh = p_h; hq = p_q; hu = p_u;
    step(8'h33, 8'h44, 1'b0);
    step(8'h80, 8'h01, 1'b0);
    step(8'hC0, 8'h7E, 1'b0);
    chk("R6 hold signed", p_s, hs);
    chk("R6 hold pattern 10", p_h, hh);
    chk("R6 hold pattern 0100", p_q, hq);
    chk("R6 hold unsigned", p_u, hu);
    // Resume: phases must continue where they stopped (R6, R8)
    for (int i = 0; i < 6; i++) step(VEC[i][7:0], VEC[i][15:8], 1'b1);

    // R7: clear between edges, observed before any edge
    en = 1'b0;
    @(posedge clk);
    #2 arst_n = 1'b0;
    #1;
    chk("R7 async clear signed", p_s, 16'h0000);
    chk("R7 async clear pattern 10", p_h, 16'h0000);
    chk("R7 async clear pattern 0100", p_q, 16'h0000);
    chk("R7 async clear unsigned", p_u, 16'h0000);
    chk("R3 clear ignored when combinational", p_c, sprod(a_in, b_in));
    @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_clear();
    // After clear the phase restarts at phase 1 (R7)
    for (int i = NV - 1; i >= 0; i--) step(VEC[i][15:8], VEC[i][7:0], 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule